// File: doc/BRIEF.md
# Loop-Disconnect Pulse Dialer

This block turns one decimal digit into a train of line breaks on an open-drain dial-pulse output. A digit arrives on a valid/ready handshake. The block then switches the line open and closed at either 10 or 20 pulses per second. The make/break split comes from a two-bit mode code. After the last break of a digit, the block inserts a fixed closed-line gap, and only then accepts the next digit. The same output also carries two other events. One is a hook-flash break whose length is chosen at run time. The other is a fixed hold that keeps the line pulled down after the handset goes off hook. The mute output is driven for as long as a digit is being pulsed.

All timing counts strobes of an external 1 kHz tick (`tick_1k`), so one tick is one millisecond. Both outputs model open-drain transistors: a 1 means the transistor is on and the pin is pulled low. For `dp_pull`, a 1 is a line break. For `mute_pull`, a 1 means mute is active.

The controller is a single state machine with six states:
- IDLE waits for work.
- BREAK holds the line open.
- MAKE closes the line between two breaks.
- GAP is the closed-line interval after a digit.
- FLASH is the hook-flash break.
- HOLD is the off-hook hold.

It has these transitions:
- IDLE goes to HOLD on the hold trigger.
- IDLE goes to FLASH on a flash request.
- IDLE goes to BREAK when it accepts a dialable digit.
- BREAK goes to MAKE when breaks remain.
- BREAK goes to GAP after the last break.
- MAKE goes back to BREAK.
- GAP, FLASH and HOLD each return to IDLE when their time runs out.

Top module: `pulse_dialer`

## Requirements
- R1: A digit code d from 1 to 9 produces d breaks, and code 0 produces 10 breaks. Codes 10 to 15 are accepted and discarded, and they produce no break.
- R2: With `rate_fast`=0 one break plus one make lasts 100 ticks. With `rate_fast`=1 it lasts 50 ticks.
- R3: With `mode_sel`=01, break:make is 60:40 ticks at the slow rate and 30:20 ticks at the fast rate.
- R4: With `mode_sel`=10 or 11, break:make is 67:33 ticks at the slow rate and 33:17 ticks at the fast rate.
- R5: With `mode_sel`=00 (tone), a digit is accepted and produces neither a break nor mute.
- R6: After the last break of a digit, the line stays closed with mute on for 800 ticks before `digit_ready` returns high.
- R7: `mute_pull` is 1 from the cycle after a pulsed digit is accepted until the end of its gap. It is 0 in idle, during a flash and during a hold.
- R8: A `flash_req` pulse in IDLE drives `dp_pull` for 73, 100, 300 or 600 ticks for `flash_sel` 00, 01, 10 or 11 respectively. This works in every mode.
- R9: An `off_hook_trig` pulse in IDLE drives `dp_pull` for 300 ticks.
- R10: In IDLE the hold trigger takes priority over a flash request, and a flash request takes priority over a digit. `digit_ready` is low whenever the block is busy, and while it is busy requests have no effect.
- R11: Mode and rate are captured when a digit is accepted. Changing them later does not alter that digit's timing.
- R12: After reset `dp_pull`=0, `mute_pull`=0 and `digit_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1k | input | 1 | One-cycle strobe per millisecond |
| rate_fast | input | 1 | 0 = 10 pulses/s, 1 = 20 pulses/s |
| mode_sel | input | 2 | 00 tone, 01 ratio 40:60, 10/11 ratio 33:67 |
| digit_valid | input | 1 | Digit request |
| digit | input | 4 | Digit code |
| digit_ready | output | 1 | Digit can be taken this cycle |
| flash_req | input | 1 | Hook-flash request strobe |
| flash_sel | input | 2 | Flash length select |
| off_hook_trig | input | 1 | Off-hook hold trigger strobe |
| dp_pull | output | 1 | Dial-pulse transistor on (line broken) |
| mute_pull | output | 1 | Mute transistor on |

## Verification
The assertions assume three things about the inputs. First, `tick_1k` is a one-cycle strobe that never arrives on two adjacent cycles. Second, the flash and hold triggers are single-cycle strobes. Third, every configured length is at least one tick. The stimulus meets these conditions in specific ways. It generates the tick every third clock, and it raises each trigger for exactly one cycle while `digit_ready` is high. It changes mode and rate only after a handshake has completed, so any change lands while a digit is in progress. Digits, modes, rates and flash selections are drawn from a fixed-seed generator. Directed cases cover digit 0, invalid codes, tone mode, the priority between triggers, and requests made while the block is busy.

// File: rtl/pdial_pkg.sv
package pdial_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BREAK,
        S_MAKE,
        S_GAP,
        S_FLASH,
        S_HOLD
    } dial_state_t;

    localparam logic [1:0] MODE_TONE = 2'b00;
    localparam logic [1:0] MODE_4060 = 2'b01;
    localparam logic [1:0] MODE_3367 = 2'b10;

    localparam logic [3:0] DIGIT_MAX = 4'd9;
    localparam logic [3:0] ZERO_PULSES = 4'd10;

endpackage

// File: rtl/pdial_timer.sv
module pdial_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = tick && (cnt_q == CNT_W'(1));

    // R2: each tick removes exactly one unit of remaining time
    a_r2_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R2: without a tick the remaining time does not move
    a_r2_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/pdial_ratio.sv
module pdial_ratio
    import pdial_pkg::*;
#(
    parameter int SLOW_PERIOD = 100,
    parameter int CNT_W       = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             rate_fast,
    output logic [CNT_W-1:0] brk_len,
    output logic [CNT_W-1:0] mk_len,
    output logic             is_tone
);

    localparam int FAST_PERIOD = SLOW_PERIOD / 2;

    logic [CNT_W-1:0] period;

    always_comb begin
        period  = rate_fast ? CNT_W'(FAST_PERIOD) : CNT_W'(SLOW_PERIOD);
        is_tone = (mode_sel == MODE_TONE);
        if (mode_sel == MODE_4060) begin
            brk_len = CNT_W'((period * CNT_W'(3)) / CNT_W'(5));
        end else begin
            brk_len = CNT_W'((period * CNT_W'(2) + CNT_W'(1)) / CNT_W'(3));
        end
        mk_len = period - brk_len;
    end

    // R4: in every pulse mode the open interval outlasts the closed one
    a_r4_break_longer: assert property (@(posedge clk) disable iff (!rst_n)
        !is_tone |-> (brk_len > mk_len && mk_len != '0));

endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer
    import pdial_pkg::*;
#(
    parameter int SLOW_PERIOD = 100,
    parameter int GAP_LEN     = 800,
    parameter int HOLD_LEN    = 300,
    parameter int FLASH_LEN0  = 73,
    parameter int FLASH_LEN1  = 100,
    parameter int FLASH_LEN2  = 300,
    parameter int FLASH_LEN3  = 600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1k,
    input  logic       rate_fast,
    input  logic [1:0] mode_sel,
    input  logic       digit_valid,
    input  logic [3:0] digit,
    output logic       digit_ready,
    input  logic       flash_req,
    input  logic [1:0] flash_sel,
    input  logic       off_hook_trig,
    output logic       dp_pull,
    output logic       mute_pull
);

    localparam int CNT_W = $clog2(GAP_LEN + HOLD_LEN + FLASH_LEN3 + 3 * SLOW_PERIOD) + 1;

    dial_state_t      state_q, state_d;
    logic [3:0]       left_q, left_d;
    logic [CNT_W-1:0] brk_q, brk_d;
    logic [CNT_W-1:0] mk_q, mk_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expire;
    logic [CNT_W-1:0] rat_brk, rat_mk;
    logic             rat_tone;
    logic [CNT_W-1:0] flash_len;

    pdial_ratio #(
        .SLOW_PERIOD(SLOW_PERIOD),
        .CNT_W      (CNT_W)
    ) u_ratio (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .rate_fast(rate_fast),
        .brk_len  (rat_brk),
        .mk_len   (rat_mk),
        .is_tone  (rat_tone)
    );

    pdial_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1k),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expire  (tmr_expire)
    );

    always_comb begin
        unique case (flash_sel)
            2'b00:   flash_len = CNT_W'(FLASH_LEN0);
            2'b01:   flash_len = CNT_W'(FLASH_LEN1);
            2'b10:   flash_len = CNT_W'(FLASH_LEN2);
            default: flash_len = CNT_W'(FLASH_LEN3);
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            left_q  <= '0;
            brk_q   <= '0;
            mk_q    <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            brk_q   <= brk_d;
            mk_q    <= mk_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        left_d   = left_q;
        brk_d    = brk_q;
        mk_d     = mk_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_IDLE: begin
                if (off_hook_trig) begin
                    state_d  = S_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HOLD_LEN);
                end else if (flash_req) begin
                    state_d  = S_FLASH;
                    tmr_load = 1'b1;
                    tmr_val  = flash_len;
                end else if (digit_valid && !rat_tone && digit <= DIGIT_MAX) begin
                    state_d  = S_BREAK;
                    left_d   = (digit == 4'd0) ? ZERO_PULSES : digit;
                    brk_d    = rat_brk;
                    mk_d     = rat_mk;
                    tmr_load = 1'b1;
                    tmr_val  = rat_brk;
                end
            end
            S_BREAK: begin
                if (tmr_expire) begin
                    left_d   = left_q - 1'b1;
                    tmr_load = 1'b1;
                    if (left_q == 4'd1) begin
                        state_d = S_GAP;
                        tmr_val = CNT_W'(GAP_LEN);
                    end else begin
                        state_d = S_MAKE;
                        tmr_val = mk_q;
                    end
                end
            end
            S_MAKE: begin
                if (tmr_expire) begin
                    state_d  = S_BREAK;
                    tmr_load = 1'b1;
                    tmr_val  = brk_q;
                end
            end
            S_GAP, S_FLASH, S_HOLD: begin
                if (tmr_expire) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dp_pull     = (state_q == S_BREAK) || (state_q == S_FLASH) || (state_q == S_HOLD);
        mute_pull   = (state_q == S_BREAK) || (state_q == S_MAKE) || (state_q == S_GAP);
        digit_ready = (state_q == S_IDLE) && !off_hook_trig && !flash_req;
    end

    // R1: break count stays within one digit's worth
    a_r1_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BREAK) |-> (left_q >= 4'd1 && left_q <= ZERO_PULSES));

    // R1: the last break leads into the gap
    a_r1_last_to_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BREAK && tmr_expire && left_q == 4'd1) |=> (state_q == S_GAP));

    // R5: a digit in tone mode leaves the machine idle
    a_r5_tone_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && digit_valid && mode_sel == MODE_TONE
         && !flash_req && !off_hook_trig) |=> (state_q == S_IDLE && !dp_pull));

    // R6: the gap returns to idle once its time runs out
    a_r6_gap_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GAP && tmr_expire) |=> (state_q == S_IDLE));

    // R10: the hold trigger wins over every other request
    a_r10_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && off_hook_trig) |=> (state_q == S_HOLD));

    // R11: captured timing is fixed while the digit is in progress
    a_r11_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MAKE) |=> ($stable(brk_q) && $stable(mk_q)));

endmodule

// File: tb/tb_pulse_dialer.sv
`timescale 1ns/1ps
module tb_pulse_dialer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1k = 1'b0;
    logic       rate_fast = 1'b0;
    logic [1:0] mode_sel = 2'b01;
    logic       digit_valid = 1'b0;
    logic [3:0] digit = 4'd0;
    logic       digit_ready;
    logic       flash_req = 1'b0;
    logic [1:0] flash_sel = 2'b00;
    logic       off_hook_trig = 1'b0;
    logic       dp_pull;
    logic       mute_pull;

    int n_cmp = 0;
    int n_bad = 0;
    int tdiv = 0;

    always #2 clk = ~clk;

    pulse_dialer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_1k      (tick_1k),
        .rate_fast    (rate_fast),
        .mode_sel     (mode_sel),
        .digit_valid  (digit_valid),
        .digit        (digit),
        .digit_ready  (digit_ready),
        .flash_req    (flash_req),
        .flash_sel    (flash_sel),
        .off_hook_trig(off_hook_trig),
        .dp_pull      (dp_pull),
        .mute_pull    (mute_pull)
    );

    always @(posedge clk) begin
        tdiv    <= (tdiv == 2) ? 0 : tdiv + 1;
        tick_1k <= (tdiv == 2);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_brk(input int md, input bit fast);
        if (md == 1) return fast ? 30 : 60;
        return fast ? 33 : 67;
    endfunction

    function automatic int exp_mk(input int md, input bit fast);
        if (md == 1) return fast ? 20 : 40;
        return fast ? 17 : 33;
    endfunction

    function automatic int exp_flash(input int sel);
        case (sel)
            0: return 73;
            1: return 100;
            2: return 300;
            default: return 600;
        endcase
    endfunction

    task automatic wait_ready();
        do @(negedge clk); while (!digit_ready);
    endtask

    // observe a quiet line for a number of ticks
    task automatic quiet(input int ticks, input string req);
        int seen = 0;
        int act = 0;
        while (seen < ticks) begin
            @(negedge clk);
            if (dp_pull || mute_pull) act++;
            if (tick_1k) seen++;
        end
        chk(act == 0, req, act, 0);
    endtask

    task automatic dial(input int d, input int md, input bit fast);
        int npl, b_exp, m_exp, runs, c1, c0, bad_b, bad_m, mute_bad;
        string rq;
        npl = (d == 0) ? 10 : ((d <= 9 && md != 0) ? d : 0);
        b_exp = exp_brk(md, fast);
        m_exp = exp_mk(md, fast);
        runs = 0; c1 = 0; c0 = 0; bad_b = 0; bad_m = 0; mute_bad = 0;
        if (md == 0) npl = 0;
        wait_ready();
        mode_sel = 2'(md);
        rate_fast = fast;
        digit = 4'(d);
        digit_valid = 1'b1;
        @(negedge clk);
        digit_valid = 1'b0;
        mode_sel = 2'($urandom % 4);   // R11: change after acceptance
        rate_fast = 1'($urandom % 2);
        if (npl == 0) begin
            chk(digit_ready == 1'b1, "R5 R1 ready after discard", int'(digit_ready), 1);
            quiet(150, "R5 R1 no pulse or mute");
            return;
        end
        forever begin
            if (digit_ready) break;
            if (!mute_pull) mute_bad++;
            if (tick_1k) begin
                if (dp_pull) begin
                    if (c0 > 0 && runs > 0 && c0 != m_exp) bad_m++;
                    c0 = 0;
                    c1++;
                end else begin
                    if (c1 > 0) begin
                        runs++;
                        if (c1 != b_exp) bad_b++;
                        c1 = 0;
                    end
                    c0++;
                end
            end
            @(negedge clk);
        end
        rq = (md == 1) ? "R3 R2 R11" : "R4 R2 R11";
        chk(runs == npl, "R1 break count", runs, npl);
        chk(bad_b == 0, {rq, " break length"}, bad_b, 0);
        chk(bad_m == 0, {rq, " make length"}, bad_m, 0);
        chk(c0 == 800, "R6 gap length", c0, 800);
        chk(mute_bad == 0, "R7 mute during digit", mute_bad, 0);
        chk(mute_pull == 1'b0, "R7 mute off in idle", int'(mute_pull), 0);
    endtask

    // raise flash and/or hold for one cycle, measure the break
    task automatic pulse_evt(input bit do_flash, input int sel, input bit do_hold,
                             input int exp_len, input string req, input bit poke);
        int c1 = 0;
        int mute_seen = 0;
        int ready_busy = 0;
        wait_ready();
        flash_sel = 2'(sel);
        flash_req = do_flash;
        off_hook_trig = do_hold;
        @(negedge clk);
        flash_req = 1'b0;
        off_hook_trig = 1'b0;
        forever begin
            if (digit_ready) break;
            if (mute_pull) mute_seen++;
            if (tick_1k && dp_pull) c1++;
            if (poke && c1 == 10) begin
                digit = 4'd5;
                digit_valid = 1'b1;
                flash_req = 1'b1;
            end else begin
                digit_valid = 1'b0;
                flash_req = 1'b0;
            end
            @(negedge clk);
        end
        digit_valid = 1'b0;
        flash_req = 1'b0;
        chk(c1 == exp_len, req, c1, exp_len);
        chk(mute_seen == 0, "R7 no mute in flash/hold", mute_seen, 0);
        if (poke) quiet(120, "R10 busy requests ignored");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(dp_pull == 1'b0, "R12 dp after reset", int'(dp_pull), 0);
        chk(mute_pull == 1'b0, "R12 mute after reset", int'(mute_pull), 0);
        chk(digit_ready == 1'b1, "R12 ready after reset", int'(digit_ready), 1);

        dial(0, 1, 1'b0);
        dial(1, 2, 1'b1);
        dial(9, 3, 1'b1);
        dial(5, 0, 1'b0);
        dial(12, 1, 1'b0);
        dial(15, 2, 1'b1);

        pulse_evt(1'b0, 0, 1'b1, 300, "R9 hold length", 1'b0);
        pulse_evt(1'b1, 3, 1'b1, 300, "R10 hold over flash", 1'b0);
        for (int s = 0; s < 4; s++) begin
            mode_sel = (s == 2) ? 2'b00 : 2'b01;
            pulse_evt(1'b1, s, 1'b0, exp_flash(s), "R8 flash length", s == 1);
        end

        for (int k = 0; k < 6; k++) begin
            int d, md;
            bit f;
            d = $urandom % 10;
            md = 1 + ($urandom % 3);
            f = 1'($urandom % 2);
            if (!f && d >= 6) d = d - 4;
            dial(d, md, f);
        end
        for (int k = 0; k < 2; k++) begin
            int s;
            s = $urandom % 4;
            pulse_evt(1'b1, s, 1'b0, exp_flash(s), "R8 flash random", 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule